// File: doc/BRIEF.md
# Boot Region Remap Decoder

This block decodes every access from two classes of bus master, processor masters and all other masters, into a target select and a decode-error flag. What the low boot region answers to is set separately for each class by a small control register. Processor masters see either the boot ROM or the on-chip RAM at address zero. Other masters see either SDRAM or the on-chip RAM there. Both memories also stay reachable at fixed high aliases whatever the control register holds.

The same register gates two bridge windows, a full-size one and a lightweight one. An access to a window that is not made visible is refused with a decode error. Software can only write the register; the block has no read path for it. The decode itself is combinational from the address and the current register contents, so one access per class can be decoded in every cycle.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset the control register is zero. A processor access to address 0 selects ROM, a non-processor access to address 0 selects SDRAM, and both bridge windows answer with a decode error.
- R2: While cfg_we_i is high at a rising clock edge, the register loads cfg_wdata_i, and accesses decode with the new value from the next cycle on. The bits are: bit 0 selects RAM for the processor low region, bit 1 selects RAM for the non-processor low region, bit 2 makes the full bridge visible, and bit 3 makes the lightweight bridge visible. While cfg_we_i is low, changes on cfg_wdata_i have no effect.
- R3: A processor access below 0x0001_0000 selects ROM when bit 0 is clear and RAM when bit 0 is set. Bit 1 does not affect processor decode.
- R4: A non-processor access below 0x0010_0000 selects SDRAM when bit 1 is clear. When bit 1 is set, an access below 0x0001_0000 selects RAM. Bit 0 does not affect non-processor decode.
- R5: When ROM or RAM is aliased at zero for a class, an access from that class in 0x0001_0000 to 0x000F_FFFF raises the error flag with target NONE.
- R6: 0xFFFD_0000 to 0xFFFD_FFFF always selects ROM, and 0xFFFF_0000 to 0xFFFF_FFFF always selects RAM, for both classes and every register value.
- R7: 0xC000_0000 to 0xFBFF_FFFF (full bridge) selects target 4 when bit 2 is set. 0xFF20_0000 to 0xFF3F_FFFF (lightweight bridge) selects target 5 when bit 3 is set. Otherwise an access to either window gives the error flag with target NONE.
- R8: 0x0010_0000 to 0xBFFF_FFFF selects SDRAM for both classes, whatever the register holds.
- R9: Any other address selects the interconnect target (6) with no error.
- R10: Without a request, a class outputs target NONE and no error.
- Target codes: NONE 0, ROM 1, RAM 2, SDRAM 3, full bridge 4, lightweight bridge 5, interconnect 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the remap control register |
| cfg_wdata_i | input | 4 | Remap control write data |
| cpu_req_i | input | 1 | Processor-class access valid |
| cpu_addr_i | input | 32 | Processor-class access address |
| cpu_tgt_o | output | 3 | Processor-class target select |
| cpu_err_o | output | 1 | Processor-class decode error |
| dev_req_i | input | 1 | Non-processor access valid |
| dev_addr_i | input | 32 | Non-processor access address |
| dev_tgt_o | output | 3 | Non-processor target select |
| dev_err_o | output | 1 | Non-processor decode error |

## Verification
The bench probes the first and last byte of every window, including 0xFFFF, 0x10000, 0xFFFFF and 0x100000. A decoder with an off-by-one span would leak RAM or ROM into the hole, or hide the first SDRAM megabyte. It sets the two low-region bits in crossed settings, so a design that swaps or shares them steers one class with the other class's bit. It toggles write data with the strobe low, which catches a register that loads without its enable. It also sweeps random addresses against random register values, which catches a bridge gate that is applied to the wrong window or that also suppresses the permanent high aliases.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  localparam int CFG_W     = 4;
  localparam int NUM_CLASS = 2;
  localparam int CLS_CPU   = 0;
  localparam int CLS_DEV   = 1;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_ROM   = 3'd1,
    TGT_RAM   = 3'd2,
    TGT_SDRAM = 3'd3,
    TGT_FBR   = 3'd4,
    TGT_LBR   = 3'd5,
    TGT_L3    = 3'd6
  } tgt_e;

  // last member is bit 0
  typedef struct packed {
    logic lbr_vis;
    logic fbr_vis;
    logic dev_low_ram;
    logic cpu_low_ram;
  } remap_cfg_t;

endpackage

// File: rtl/remap_ctrl_reg.sv
module remap_ctrl_reg
  import boot_remap_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CFG_W-1:0]     wdata_i,
  output remap_cfg_t           cfg_o
);

  remap_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= remap_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/remap_win_match.sv
module remap_win_match #(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = '0,
  parameter logic [ADDR_W-1:0] SIZE   = 'h1_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  logic [ADDR_W-1:0] offs;

  assign offs  = addr_i - BASE;
  assign hit_o = (addr_i >= BASE) && (offs < SIZE);

endmodule

// File: rtl/remap_port_decode.sv
module remap_port_decode
  import boot_remap_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter bit                IS_CPU      = 1'b1,
  parameter logic [ADDR_W-1:0] BOOT_SPAN   = 'h0001_0000,
  parameter logic [ADDR_W-1:0] LOW_SPAN    = 'h0010_0000,
  parameter logic [ADDR_W-1:0] SDRAM_TOP   = 'hC000_0000,
  parameter logic [ADDR_W-1:0] ROM_HI_BASE = 'hFFFD_0000,
  parameter logic [ADDR_W-1:0] RAM_HI_BASE = 'hFFFF_0000,
  parameter logic [ADDR_W-1:0] FBR_BASE    = 'hC000_0000,
  parameter logic [ADDR_W-1:0] FBR_SIZE    = 'h3C00_0000,
  parameter logic [ADDR_W-1:0] LBR_BASE    = 'hFF20_0000,
  parameter logic [ADDR_W-1:0] LBR_SIZE    = 'h0020_0000
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              alias_ram_i,
  input  logic              fbr_vis_i,
  input  logic              lbr_vis_i,
  output tgt_e              tgt_o,
  output logic              err_o
);

  localparam logic [ADDR_W-1:0] SDRAM_SPAN = SDRAM_TOP - LOW_SPAN;

  logic hit_boot, hit_low, hit_rom, hit_ram, hit_fbr, hit_lbr, hit_sdram;

  remap_win_match #(.ADDR_W(ADDR_W), .BASE('0),          .SIZE(BOOT_SPAN))
    u_boot  (.addr_i(addr_i), .hit_o(hit_boot));
  remap_win_match #(.ADDR_W(ADDR_W), .BASE('0),          .SIZE(LOW_SPAN))
    u_low   (.addr_i(addr_i), .hit_o(hit_low));
  remap_win_match #(.ADDR_W(ADDR_W), .BASE(ROM_HI_BASE), .SIZE(BOOT_SPAN))
    u_rom   (.addr_i(addr_i), .hit_o(hit_rom));
  remap_win_match #(.ADDR_W(ADDR_W), .BASE(RAM_HI_BASE), .SIZE(BOOT_SPAN))
    u_ram   (.addr_i(addr_i), .hit_o(hit_ram));
  remap_win_match #(.ADDR_W(ADDR_W), .BASE(FBR_BASE),    .SIZE(FBR_SIZE))
    u_fbr   (.addr_i(addr_i), .hit_o(hit_fbr));
  remap_win_match #(.ADDR_W(ADDR_W), .BASE(LBR_BASE),    .SIZE(LBR_SIZE))
    u_lbr   (.addr_i(addr_i), .hit_o(hit_lbr));
  remap_win_match #(.ADDR_W(ADDR_W), .BASE(LOW_SPAN),    .SIZE(SDRAM_SPAN))
    u_sdram (.addr_i(addr_i), .hit_o(hit_sdram));

  // alias_on: low region is limited to a 64 KB memory; else SDRAM fills it
  logic alias_on;
  tgt_e alias_tgt;

  generate
    if (IS_CPU) begin : g_cpu
      assign alias_on  = 1'b1;
      assign alias_tgt = alias_ram_i ? TGT_RAM : TGT_ROM;
    end else begin : g_dev
      assign alias_on  = alias_ram_i;
      assign alias_tgt = TGT_RAM;
    end
  endgenerate

  always_comb begin
    tgt_o = TGT_NONE;
    err_o = 1'b0;
    if (req_i) begin
      if (hit_low) begin
        if (!alias_on)     tgt_o = TGT_SDRAM;
        else if (hit_boot) tgt_o = alias_tgt;
        else               err_o = 1'b1;
      end else if (hit_rom) begin
        tgt_o = TGT_ROM;
      end else if (hit_ram) begin
        tgt_o = TGT_RAM;
      end else if (hit_fbr) begin
        if (fbr_vis_i) tgt_o = TGT_FBR;
        else           err_o = 1'b1;
      end else if (hit_lbr) begin
        if (lbr_vis_i) tgt_o = TGT_LBR;
        else           err_o = 1'b1;
      end else if (hit_sdram) begin
        tgt_o = TGT_SDRAM;
      end else begin
        tgt_o = TGT_L3;
      end
    end
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_remap_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BOOT_SPAN   = 'h0001_0000,
  parameter logic [ADDR_W-1:0] LOW_SPAN    = 'h0010_0000,
  parameter logic [ADDR_W-1:0] SDRAM_TOP   = 'hC000_0000,
  parameter logic [ADDR_W-1:0] ROM_HI_BASE = 'hFFFD_0000,
  parameter logic [ADDR_W-1:0] RAM_HI_BASE = 'hFFFF_0000,
  parameter logic [ADDR_W-1:0] FBR_BASE    = 'hC000_0000,
  parameter logic [ADDR_W-1:0] FBR_SIZE    = 'h3C00_0000,
  parameter logic [ADDR_W-1:0] LBR_BASE    = 'hFF20_0000,
  parameter logic [ADDR_W-1:0] LBR_SIZE    = 'h0020_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [2:0]        cpu_tgt_o,
  output logic              cpu_err_o,
  input  logic              dev_req_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic [2:0]        dev_tgt_o,
  output logic              dev_err_o
);

  remap_cfg_t cfg;

  remap_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  logic              req_v   [NUM_CLASS];
  logic [ADDR_W-1:0] addr_v  [NUM_CLASS];
  logic              alias_v [NUM_CLASS];
  tgt_e              tgt_v   [NUM_CLASS];
  logic              err_v   [NUM_CLASS];

  assign req_v[CLS_CPU]   = cpu_req_i;
  assign addr_v[CLS_CPU]  = cpu_addr_i;
  assign alias_v[CLS_CPU] = cfg.cpu_low_ram;
  assign req_v[CLS_DEV]   = dev_req_i;
  assign addr_v[CLS_DEV]  = dev_addr_i;
  assign alias_v[CLS_DEV] = cfg.dev_low_ram;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    remap_port_decode #(
      .ADDR_W(ADDR_W), .IS_CPU(c == CLS_CPU),
      .BOOT_SPAN(BOOT_SPAN), .LOW_SPAN(LOW_SPAN), .SDRAM_TOP(SDRAM_TOP),
      .ROM_HI_BASE(ROM_HI_BASE), .RAM_HI_BASE(RAM_HI_BASE),
      .FBR_BASE(FBR_BASE), .FBR_SIZE(FBR_SIZE),
      .LBR_BASE(LBR_BASE), .LBR_SIZE(LBR_SIZE)
    ) u_dec (
      .req_i       (req_v[c]),
      .addr_i      (addr_v[c]),
      .alias_ram_i (alias_v[c]),
      .fbr_vis_i   (cfg.fbr_vis),
      .lbr_vis_i   (cfg.lbr_vis),
      .tgt_o       (tgt_v[c]),
      .err_o       (err_v[c])
    );
  end

  assign cpu_tgt_o = tgt_v[CLS_CPU];
  assign cpu_err_o = err_v[CLS_CPU];
  assign dev_tgt_o = tgt_v[CLS_DEV];
  assign dev_err_o = err_v[CLS_DEV];

endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BOOT_SPAN   = 'h0001_0000,
  parameter logic [ADDR_W-1:0] LOW_SPAN    = 'h0010_0000,
  parameter logic [ADDR_W-1:0] ROM_HI_BASE = 'hFFFD_0000,
  parameter logic [ADDR_W-1:0] FBR_BASE    = 'hC000_0000,
  parameter logic [ADDR_W-1:0] FBR_SIZE    = 'h3C00_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [3:0]        cfg_wdata_i,
  input logic              cpu_req_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [2:0]        cpu_tgt_o,
  input logic              cpu_err_o,
  input logic              dev_req_i,
  input logic [ADDR_W-1:0] dev_addr_i,
  input logic [2:0]        dev_tgt_o,
  input logic              dev_err_o
);

  logic [3:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shadow_q <= '0;
    else if (cfg_we_i) shadow_q <= cfg_wdata_i;
  end

  logic cpu_in_rom_hi, dev_in_fbr;
  assign cpu_in_rom_hi = (cpu_addr_i >= ROM_HI_BASE) && ((cpu_addr_i - ROM_HI_BASE) < BOOT_SPAN);
  assign dev_in_fbr    = (dev_addr_i >= FBR_BASE) && ((dev_addr_i - FBR_BASE) < FBR_SIZE);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> (cpu_tgt_o == 3'd0) && !cpu_err_o); // R10
  AST_ERR_NO_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_err_o |-> dev_tgt_o == 3'd0); // R5
  AST_CPU_LOW_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && (cpu_addr_i < BOOT_SPAN) |-> cpu_tgt_o == (shadow_q[0] ? 3'd2 : 3'd1)); // R3
  AST_DEV_LOW_SDRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_i && (dev_addr_i < LOW_SPAN) && !shadow_q[1] |-> dev_tgt_o == 3'd3); // R4
  AST_ROM_HI_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_in_rom_hi |-> (cpu_tgt_o == 3'd1) && !cpu_err_o); // R6
  AST_FBR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_i && dev_in_fbr && !shadow_q[2] |-> dev_err_o); // R7

endmodule

bind boot_remap_decoder boot_remap_chk #(
  .ADDR_W(ADDR_W), .BOOT_SPAN(BOOT_SPAN), .LOW_SPAN(LOW_SPAN),
  .ROM_HI_BASE(ROM_HI_BASE), .FBR_BASE(FBR_BASE), .FBR_SIZE(FBR_SIZE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i), .cpu_tgt_o(cpu_tgt_o), .cpu_err_o(cpu_err_o),
  .dev_req_i(dev_req_i), .dev_addr_i(dev_addr_i), .dev_tgt_o(dev_tgt_o), .dev_err_o(dev_err_o)
);

// File: tb/sim_boot_remap_decoder.sv
module sim_boot_remap_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [3:0]  cfg_wdata_i;
  logic        cpu_req_i, dev_req_i;
  logic [31:0] cpu_addr_i, dev_addr_i;
  logic [2:0]  cpu_tgt_o, dev_tgt_o;
  logic        cpu_err_o, dev_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [3:0] model_cfg = 4'h0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  boot_remap_decoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i), .cpu_tgt_o(cpu_tgt_o), .cpu_err_o(cpu_err_o),
    .dev_req_i(dev_req_i), .dev_addr_i(dev_addr_i), .dev_tgt_o(dev_tgt_o), .dev_err_o(dev_err_o)
  );

  // {err, tgt[2:0]}
  function automatic logic [3:0] exp_dec(bit is_cpu, logic req, logic [31:0] a, logic [3:0] c);
    if (!req) return 4'h0;
    if (a < 32'h0010_0000) begin
      if (is_cpu)     return (a < 32'h1_0000) ? (c[0] ? 4'h2 : 4'h1) : 4'h8;
      else if (!c[1]) return 4'h3;
      else            return (a < 32'h1_0000) ? 4'h2 : 4'h8;
    end
    if (a >= 32'hFFFD_0000 && a <= 32'hFFFD_FFFF) return 4'h1;
    if (a >= 32'hFFFF_0000)                       return 4'h2;
    if (a >= 32'hC000_0000 && a <= 32'hFBFF_FFFF) return c[2] ? 4'h4 : 4'h8;
    if (a >= 32'hFF20_0000 && a <= 32'hFF3F_FFFF) return c[3] ? 4'h5 : 4'h8;
    if (a < 32'hC000_0000)                        return 4'h3;
    return 4'h6;
  endfunction

  function automatic logic [31:0] rand_addr();
    case ($urandom % 9)
      0: return $urandom % 32'h1_0000;
      1: return $urandom % 32'h10_0000;
      2: return 32'h10_0000 + ($urandom % 32'hBFF0_0000);
      3: return 32'hC000_0000 + ($urandom % 32'h3C00_0000);
      4: return 32'hFF20_0000 + ($urandom % 32'h20_0000);
      5: return 32'hFFFD_0000 + ($urandom % 32'h1_0000);
      6: return 32'hFFFF_0000 + ($urandom % 32'h1_0000);
      7: return 32'hFC00_0000 + ($urandom % 32'h0320_0000);
      default: return $urandom;
    endcase
  endfunction

  // drive at negedge, compare 1 time unit later (decode is combinational)
  task automatic probe(input logic creq, input logic [31:0] ca,
                       input logic dreq, input logic [31:0] da, input string tag);
    logic [3:0] ec, ed;
    @(negedge clk_i);
    cpu_req_i = creq; cpu_addr_i = ca; dev_req_i = dreq; dev_addr_i = da;
    #1;
    ec = exp_dec(1'b1, creq, ca, model_cfg);
    ed = exp_dec(1'b0, dreq, da, model_cfg);
    n_chk += 2;
    if ({cpu_err_o, cpu_tgt_o} !== ec) begin
      n_fail++;
      $display("FAIL %s cpu addr=%h got=%h exp=%h", tag, ca, {cpu_err_o, cpu_tgt_o}, ec);
    end
    if ({dev_err_o, dev_tgt_o} !== ed) begin
      n_fail++;
      $display("FAIL %s dev addr=%h got=%h exp=%h", tag, da, {dev_err_o, dev_tgt_o}, ed);
    end
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    model_cfg = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = '0;
    cpu_req_i = 1'b0; dev_req_i = 1'b0; cpu_addr_i = '0; dev_addr_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    probe(1, 32'h0,         1, 32'h0,         "R1 low");
    probe(1, 32'hC000_0000, 1, 32'hFF20_0000, "R1 bridges");
    probe(1, 32'hFF3F_FFFF, 1, 32'hFBFF_FFFF, "R1 bridge ends");
    // R5 cpu hole with ROM aliased, R4 dev SDRAM across low region
    probe(1, 32'h1_0000,    1, 32'hF_FFFF,    "R5 R4 hole edge");
    probe(1, 32'hFFFF,      1, 32'h1_0000,    "R3 R4 boot top");

    write_cfg(4'b1111);
    probe(1, 32'h0,         1, 32'h0,         "R2 R3 R4 ram alias");
    probe(1, 32'hF_FFFF,    1, 32'h1_0000,    "R5 hole");
    probe(1, 32'hC000_0000, 1, 32'hFF20_0000, "R7 visible");
    probe(1, 32'hFBFF_FFFF, 1, 32'hFF3F_FFFF, "R7 visible ends");
    probe(1, 32'hFFFD_0000, 1, 32'hFFFF_FFFF, "R6 high aliases");
    probe(1, 32'h10_0000,   1, 32'hBFFF_FFFF, "R8 sdram edges");
    probe(1, 32'hFC00_0000, 1, 32'hFFFE_0000, "R9 interconnect");
    probe(1, 32'hFF1F_FFFF, 1, 32'hFF40_0000, "R9 around lbr");
    probe(0, 32'h0,         0, 32'hC000_0000, "R10 idle");

    // R2 data without strobe is ignored
    @(negedge clk_i) cfg_wdata_i = 4'b0000;
    repeat (2) @(negedge clk_i);
    probe(1, 32'h0,         1, 32'h8000,      "R2 no strobe");

    // crossed settings: R3 and R4 bits independent
    write_cfg(4'b0010);
    probe(1, 32'h0,         1, 32'h0,         "R3 R4 crossed a");
    write_cfg(4'b0001);
    probe(1, 32'h0,         1, 32'h8_0000,    "R3 R4 crossed b");
    write_cfg(4'b0100);
    probe(1, 32'hFF20_0000, 1, 32'hC000_0000, "R7 split a");
    write_cfg(4'b1000);
    probe(1, 32'hFF20_0000, 1, 32'hC000_0000, "R7 split b");
    probe(1, 32'hFFFD_FFFF, 1, 32'hFFFF_0000, "R6 any cfg");

    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 8)
        0: write_cfg(4'($urandom));
        1: @(negedge clk_i) cfg_wdata_i = 4'($urandom);
        default: ;
      endcase
      probe(1'($urandom % 8 != 0), rand_addr(), 1'($urandom % 8 != 0), rand_addr(),
            "R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule